// File: doc/BRIEF.md
# Streaming Absolute-Value Accumulator

This block is a single-token dataflow stage. It takes signed integer tokens on a valid/ready input stream and keeps a running total of their magnitudes. Each accepted token causes exactly one firing. That firing updates the total and places the new total on a valid/ready output stream. The stage sits between two handshaked streams, for example after a sample source that feeds a magnitude-energy estimate. The total persists across tokens until a synchronous reset clears it.

A firing picks one of two mutually exclusive guarded actions based on the sign of the token. A non-negative token is added to the total. A negative token is subtracted from it. The accumulator has a configurable number of guard bits above the input width, and it wraps silently when it overflows.

A two-state machine controls the output slot. The states are `SLOT_EMPTY` and `SLOT_HELD`, with these transitions:
- *load*: `SLOT_EMPTY` to `SLOT_HELD` on a firing.
- *refill*: `SLOT_HELD` to `SLOT_HELD` on a firing in the same cycle the consumer takes the held token.
- *stall*: `SLOT_HELD` to `SLOT_HELD` while the consumer is not ready.
- *drain*: `SLOT_HELD` to `SLOT_EMPTY` when the held token is taken and no new token arrives.

Top module: `absacc_stream`

## Requirements
- R1: A synchronous reset sets the running total to zero and empties the output slot, so `out_valid` is 0 after reset. The first token after reset yields its own magnitude.
- R2: A token with sign bit 0 (value zero or positive) fires the add action, and the total becomes total plus value.
- R3: A token with sign bit 1 (negative, two's complement) fires the subtract action, and the total becomes total minus value.
- R4: Every consumed token produces exactly one output token. That output token carries the total after the update, and it appears on `out_data` with `out_valid` high one clock after the consuming edge.
- R5: `in_ready` is high when the slot is empty or the consumer is ready. A token is consumed only on an edge where both `in_valid` and `in_ready` are high. Without a consumed token the total does not change.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged and no input is consumed.
- R7: The total is `DATA_W+GUARD_W` bits wide and wraps modulo 2^(`DATA_W+GUARD_W`).
- R8: The most negative input, -2^(`DATA_W`-1), adds exactly 2^(`DATA_W`-1) to the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Stage can accept a token |
| in_data | input | DATA_W | Signed two's-complement token |
| out_valid | output | 1 | Output slot holds a token |
| out_ready | input | 1 | Consumer accepts the output token |
| out_data | output | DATA_W+GUARD_W | Running total after the firing |

## Verification
There is one register between a consuming edge and the output. A result is therefore due one clock after the edge where `in_valid` and `in_ready` were both high. The bench drives inputs on falling edges and reads the response on the next falling edge, which lies half a period after the consuming edge. `in_ready` is combinational, so it is checked in the same half-cycle as the stimulus. The stall checks read the held token on each falling edge of the stall. The token queued behind the stall is expected one clock after `out_ready` rises.

// File: rtl/absacc_pkg.sv
package absacc_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_t;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } action_t;

endpackage

// File: rtl/absacc_guard.sv
module absacc_guard
    import absacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 12
) (
    input  logic              fire,
    input  logic [DATA_W-1:0] token,
    output action_t           act,
    output logic [SUM_W-1:0]  operand
);
    localparam int EXT_W = SUM_W - DATA_W;

    // Sign-extend the token to accumulator width.
    assign operand = {{EXT_W{token[DATA_W-1]}}, token};

    // Two mutually exclusive guards, selected by the sign bit.
    always_comb begin
        if (!fire)
            act = ACT_IDLE;
        else if (token[DATA_W-1])
            act = ACT_SUB;
        else
            act = ACT_ADD;
    end
endmodule

// File: rtl/absacc_sum.sv
module absacc_sum
    import absacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  action_t          act,
    input  logic [SUM_W-1:0] operand,
    output logic [SUM_W-1:0] sum_q,
    output logic [SUM_W-1:0] sum_d
);
    localparam logic [SUM_W-1:0] MAX_STEP = SUM_W'(1) << (DATA_W - 1);

    always_comb begin
        unique case (act)
            ACT_ADD: sum_d = sum_q + operand;
            ACT_SUB: sum_d = sum_q - operand;
            default: sum_d = sum_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end

    // R7/R8: one firing moves the total by at most 2^(DATA_W-1), modulo wrap.
    p_step_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_IDLE) |=> ((sum_q - $past(sum_q)) <= MAX_STEP));

    // R5: an idle cycle leaves the total alone.
    p_idle_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_IDLE) |=> $stable(sum_q));
endmodule

// File: rtl/absacc_slot.sv
module absacc_slot
    import absacc_pkg::*;
#(
    parameter int SUM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [SUM_W-1:0] next_sum,
    input  logic             out_ready,
    output logic             accept,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_data
);
    slot_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (fire) state_d = SLOT_HELD;           // load
            SLOT_HELD:  if (fire) state_d = SLOT_HELD;           // refill
                        else if (out_ready) state_d = SLOT_EMPTY; // drain
                        else state_d = SLOT_HELD;                 // stall
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SLOT_EMPTY;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_data <= '0;
        else if (fire)
            out_data <= next_sum;
    end

    assign out_valid = (state_q == SLOT_HELD);
    assign accept    = (state_q == SLOT_EMPTY) || out_ready;

    // R6: a stalled token stays put.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: every firing lands a token in the slot.
    p_fire_emits_r4: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);
endmodule

// File: rtl/absacc_stream.sv
module absacc_stream
    import absacc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_W+GUARD_W-1:0]  out_data
);
    localparam int SUM_W = DATA_W + GUARD_W;

    logic             fire;
    action_t          act;
    logic [SUM_W-1:0] operand;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_d;

    assign fire = in_valid && in_ready;

    absacc_guard #(.DATA_W(DATA_W), .SUM_W(SUM_W)) guard_i (
        .fire    (fire),
        .token   (in_data),
        .act     (act),
        .operand (operand)
    );

    absacc_sum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) sum_i (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .operand (operand),
        .sum_q   (sum_q),
        .sum_d   (sum_d)
    );

    absacc_slot #(.SUM_W(SUM_W)) slot_i (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .next_sum  (sum_d),
        .out_ready (out_ready),
        .accept    (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R4: the held token is the total after its own update.
    p_out_is_total_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == sum_q));

    // R1: the cycle after reset has an empty slot and a zero total.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && (sum_q == '0)));

    // R2: a non-negative token moves the total up by its value.
    p_add_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && !in_data[DATA_W-1]) |=>
            ((sum_q - $past(sum_q)) == SUM_W'($past(in_data))));

    // R3: a negative token moves the total down by its value.
    p_sub_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && in_data[DATA_W-1]) |=>
            (($past(sum_q) - sum_q) == {{GUARD_W{1'b1}}, $past(in_data)}));

    // R6: no consumption while the slot is stalled.
    p_stall_block_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !fire);
endmodule

// File: tb/absacc_stream_tb.sv
module absacc_stream_tb_top;
    localparam int DATA_W  = 8;
    localparam int GUARD_W = 4;
    localparam int SUM_W   = DATA_W + GUARD_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [SUM_W-1:0]  out_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [SUM_W-1:0] model = '0;
    int raw_total = 0;

    always #2 clk = ~clk;

    absacc_stream #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mag(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic add_model(input int v);
        model     = model + SUM_W'(mag(v));
        raw_total = raw_total + mag(v);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset slot", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R5 ready when empty", int'(in_ready), 1);

        // Sweep every input value, one token then an idle cycle.
        for (int v = -128; v < 128; v++) begin
            in_valid = 1'b1;
            in_data  = DATA_W'(v);
            add_model(v);
            @(negedge clk);
            in_valid = 1'b0;
            if (v == -128)
                chk(out_data == model, "R8 most negative", int'(out_data), int'(model));
            else if (v < 0)
                chk(out_data == model, "R3 negative token", int'(out_data), int'(model));
            else
                chk(out_data == model, "R2 nonnegative token", int'(out_data), int'(model));
            chk(out_valid == 1'b1, "R4 output present", int'(out_valid), 1);
            @(negedge clk);
            chk(out_valid == 1'b0, "R4 one output per token", int'(out_valid), 0);
        end
        chk(raw_total >= (1 << SUM_W), "R7 sweep overflowed", raw_total, 1 << SUM_W);
        chk(out_data == SUM_W'(raw_total), "R7 wrap", int'(out_data), raw_total % (1 << SUM_W));

        // Back-to-back stream without gaps.
        for (int k = 0; k < 16; k++) begin
            int v;
            v = (k % 2 == 0) ? (k * 7 - 60) : (100 - k * 9);
            in_valid = 1'b1;
            in_data  = DATA_W'(v);
            add_model(v);
            @(negedge clk);
            chk(out_valid && (out_data == model), "R4 streaming total", int'(out_data), int'(model));
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 no input no output", int'(out_valid), 0);

        // Stall: first token lands, second waits.
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = DATA_W'(-45);
        add_model(-45);
        @(negedge clk);
        chk(out_valid && (out_data == model), "R6 stalled token", int'(out_data), int'(model));
        in_data = DATA_W'(33);
        chk(in_ready == 1'b0, "R5 not ready while stalled", int'(in_ready), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid && (out_data == model), "R6 held stable", int'(out_data), int'(model));
        end
        out_ready = 1'b1;
        #0;
        chk(in_ready == 1'b1, "R5 ready on drain", int'(in_ready), 1);
        add_model(33);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && (out_data == model), "R6 queued token once", int'(out_data), int'(model));
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 drained", int'(out_valid), 0);

        // Reset with a stalled token held.
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = DATA_W'(90);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1 reset drops token", int'(out_valid), 0);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = DATA_W'(-5);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data == SUM_W'(5), "R1 total cleared", int'(out_data), 5);

        summary();
        $finish;
    end
endmodule